// File: doc/BRIEF.md
# Video Controller Status Word and HV Counter Readout

This block builds the two read-only words a CPU sees on the control side of a video display controller: a 16-bit status word and a 16-bit horizontal/vertical (HV) position word. It takes the CPU's current cycle position inside the scanline, the display-width mode, the vertical line counter, the FIFO fill level, the DMA and vertical-blank state, and the counter-freeze bit from the first mode register. All results are registered, so each appears one clock after its inputs.

The horizontal part of the HV word is the line position, reduced modulo 512, scaled by a per-mode multiplier. When the freeze bit rises, the current HV word is captured and returned until the bit is cleared. The horizontal-blank flag comes from a window whose start and length depend on the width mode. The FIFO flags come from the fill level, and DMA overrides them. The block also keeps the flag that records a half-written two-word command. A status read clears that flag.

Top module: `hvstat_top`

## Requirements
- R1: After reset, statusWord, hvWord and cmdPending are all zero.
- R2: Let p be linePos modulo 512. While latchEnable is low, hvWord[15:8] equals vCount and hvWord[7:0] equals floor(p*M/256), with M=110 when wideMode=1 and M=90 when wideMode=0.
- R3: In the clock where latchEnable is first seen high after being low, the live HV value is captured and output. For as long as latchEnable stays high, hvWord keeps that captured value whatever linePos and vCount do.
- R4: Capture happens only on the low-to-high change of latchEnable. Holding the bit high never refreshes the captured value. Dropping it and raising it again captures anew.
- R5: statusWord bit 2 (horizontal blank) is set exactly when (p - S) modulo 512 is below L. S=32 and L=94 when wideMode=1. S=40 and L=84 when wideMode=0.
- R6: statusWord bit 0 (empty) is set when fifoLevel is 0 or dmaActive is 1.
- R7: statusWord bit 1 (full) is set when fifoLevel is 4 or more and dmaActive is 0. Bits 0 and 1 are never set together.
- R8: statusWord bit 3 mirrors vblank and bit 4 mirrors dmaActive. Bits 15:5 are zero.
- R9: cmdFirstHalf sets cmdPending. statusRead clears it, and the clear wins when both strobes come in the same clock.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| linePos | input | 16 | CPU cycle position within the current line |
| wideMode | input | 1 | 1 selects the wide display mode, 0 the narrow one |
| vCount | input | 8 | Vertical line counter |
| latchEnable | input | 1 | Counter-freeze bit from mode register 0 |
| fifoLevel | input | 4 | Number of pending FIFO entries |
| dmaActive | input | 1 | DMA transfer in progress |
| vblank | input | 1 | Vertical blank state |
| cmdFirstHalf | input | 1 | Strobe: first word of a command was written |
| statusRead | input | 1 | Strobe: either status byte was read |
| statusWord | output | 16 | Assembled status word |
| hvWord | output | 16 | Live or frozen HV counter word |
| cmdPending | output | 1 | A half-written command is outstanding |

## Verification
Every result of this block (the HV word, each status flag and the pending flag) is due exactly one clock after the edge that samples its inputs. The bench changes inputs on the falling edge and reads the outputs shortly after the following rising edge. For the freeze bit, the capture clock is the first edge that sees the bit high. The bench then changes position and line count over several later clocks and checks that the word stays fixed. Blank-window and modulo corners are placed on the first and last positions inside and outside each window.

// File: rtl/hvstat_pkg.sv
package hvstat_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // freeze bit just rose: store live value
    logic holdSel;   // freeze bit held: present stored value
  } ctrlStrobes_t;

  // status word bit positions
  localparam int BIT_EMPTY  = 0;
  localparam int BIT_FULL   = 1;
  localparam int BIT_HBLANK = 2;
  localparam int BIT_VBLANK = 3;
  localparam int BIT_DMA    = 4;

endpackage

// File: rtl/hvstat_ctrl.sv
module hvstat_ctrl
  import hvstat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latchEnable,
  input  logic         cmdFirstHalf,
  input  logic         statusRead,
  output ctrlStrobes_t strobes,
  output logic         latchPrev,
  output logic         cmdPending
);

  logic enablePrev;

  always_ff @(posedge clk) begin
    if (!rst_n) enablePrev <= 1'b0;
    else        enablePrev <= latchEnable;
  end

  // edge detection: capture only on the rise (R4)
  always_comb begin
    strobes.capture = latchEnable & ~enablePrev;
    strobes.holdSel = latchEnable &  enablePrev;
  end

  // half-command flag: a read clears it and wins over a set (R9)
  always_ff @(posedge clk) begin
    if (!rst_n)            cmdPending <= 1'b0;
    else if (statusRead)   cmdPending <= 1'b0;
    else if (cmdFirstHalf) cmdPending <= 1'b1;
  end

  assign latchPrev = enablePrev;

endmodule

// File: rtl/hvstat_datapath.sv
module hvstat_datapath
  import hvstat_pkg::*;
#(
  parameter int POS_W          = 16,
  parameter int MOD_W          = 9,
  parameter int V_W            = 8,
  parameter int LVL_W          = 4,
  parameter int FIFO_DEPTH     = 4,
  parameter int HMUL_W         = 8,
  parameter int WIDE_HMUL      = 110,
  parameter int NARROW_HMUL    = 90,
  parameter int WIDE_HB_START  = 32,
  parameter int WIDE_HB_LEN    = 94,
  parameter int NARROW_HB_START = 40,
  parameter int NARROW_HB_LEN  = 84,
  parameter int STAT_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [POS_W-1:0]  linePos,
  input  logic              wideMode,
  input  logic [V_W-1:0]    vCount,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              dmaActive,
  input  logic              vblank,
  output logic [STAT_W-1:0] statusWord,
  output logic [2*V_W-1:0]  hvWord
);

  localparam int PROD_W = MOD_W + HMUL_W;
  localparam int HV_W   = 2 * V_W;

  logic [MOD_W-1:0]  posMod;
  logic [MOD_W-1:0]  hbStart, hbLen, hbOffset;
  logic [HMUL_W-1:0] hMul;
  logic [PROD_W-1:0] hProd;
  logic [V_W-1:0]    hCount;
  logic [HV_W-1:0]   liveHv, heldHv;
  logic              hBlank, fifoEmpty, fifoFull;
  logic [STAT_W-1:0] statusNext;

  assign posMod = linePos[MOD_W-1:0];

  // per-mode constants
  always_comb begin
    if (wideMode) begin
      hbStart = MOD_W'(WIDE_HB_START);
      hbLen   = MOD_W'(WIDE_HB_LEN);
      hMul    = HMUL_W'(WIDE_HMUL);
    end else begin
      hbStart = MOD_W'(NARROW_HB_START);
      hbLen   = MOD_W'(NARROW_HB_LEN);
      hMul    = HMUL_W'(NARROW_HMUL);
    end
  end

  // wrapping window compare
  assign hbOffset = posMod - hbStart;
  assign hBlank   = hbOffset < hbLen;

  // horizontal count mapping
  assign hProd  = {{HMUL_W{1'b0}}, posMod} * {{MOD_W{1'b0}}, hMul};
  assign hCount = hProd[HMUL_W +: V_W];
  assign liveHv = {vCount, hCount};

  // FIFO flags, DMA forces empty
  assign fifoEmpty = dmaActive | (fifoLevel == '0);
  assign fifoFull  = ~dmaActive & (fifoLevel >= LVL_W'(FIFO_DEPTH));

  always_comb begin
    statusNext             = '0;
    statusNext[BIT_EMPTY]  = fifoEmpty;
    statusNext[BIT_FULL]   = fifoFull;
    statusNext[BIT_HBLANK] = hBlank;
    statusNext[BIT_VBLANK] = vblank;
    statusNext[BIT_DMA]    = dmaActive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldHv     <= '0;
      hvWord     <= '0;
      statusWord <= '0;
    end else begin
      if (strobes.capture) heldHv <= liveHv;
      hvWord     <= strobes.holdSel ? heldHv : liveHv;
      statusWord <= statusNext;
    end
  end

endmodule

// File: rtl/hvstat_top.sv
module hvstat_top
  import hvstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] linePos,
  input  logic        wideMode,
  input  logic [7:0]  vCount,
  input  logic        latchEnable,
  input  logic [3:0]  fifoLevel,
  input  logic        dmaActive,
  input  logic        vblank,
  input  logic        cmdFirstHalf,
  input  logic        statusRead,
  output logic [15:0] statusWord,
  output logic [15:0] hvWord,
  output logic        cmdPending
);

  ctrlStrobes_t strobes;
  logic         latchPrev;

  hvstat_ctrl ctrlU (
    .clk          (clk),
    .rst_n        (rst_n),
    .latchEnable  (latchEnable),
    .cmdFirstHalf (cmdFirstHalf),
    .statusRead   (statusRead),
    .strobes      (strobes),
    .latchPrev    (latchPrev),
    .cmdPending   (cmdPending)
  );

  hvstat_datapath #(
    .POS_W (16),
    .V_W   (8),
    .LVL_W (4),
    .STAT_W(16)
  ) dpU (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .linePos    (linePos),
    .wideMode   (wideMode),
    .vCount     (vCount),
    .fifoLevel  (fifoLevel),
    .dmaActive  (dmaActive),
    .vblank     (vblank),
    .statusWord (statusWord),
    .hvWord     (hvWord)
  );

endmodule

// File: rtl/hvstat_checker.sv
module hvstat_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  vCount,
  input logic        latchEnable,
  input logic        latchPrev,
  input logic        dmaActive,
  input logic        vblank,
  input logic        cmdFirstHalf,
  input logic        statusRead,
  input logic [15:0] statusWord,
  input logic [15:0] hvWord,
  input logic        cmdPending
);

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (latchEnable && latchPrev) |=> $stable(hvWord));

  assert_live_vcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !latchEnable |=> (hvWord[15:8] == $past(vCount)));

  assert_dma_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmaActive |=> (statusWord[0] && !statusWord[1]));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(statusWord[0] && statusWord[1]));

  assert_vblank_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (statusWord[3] == $past(vblank)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    statusRead |=> !cmdPending);

  assert_half_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdFirstHalf && !statusRead) |=> cmdPending);

endmodule

bind hvstat_top hvstat_checker checkU (
  .clk          (clk),
  .rst_n        (rst_n),
  .vCount       (vCount),
  .latchEnable  (latchEnable),
  .latchPrev    (latchPrev),
  .dmaActive    (dmaActive),
  .vblank       (vblank),
  .cmdFirstHalf (cmdFirstHalf),
  .statusRead   (statusRead),
  .statusWord   (statusWord),
  .hvWord       (hvWord),
  .cmdPending   (cmdPending)
);

// File: tb/hvstat_top_test.sv
`timescale 1ns/100ps
module hvstat_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] linePos;
  logic        wideMode;
  logic [7:0]  vCount;
  logic        latchEnable;
  logic [3:0]  fifoLevel;
  logic        dmaActive;
  logic        vblank;
  logic        cmdFirstHalf;
  logic        statusRead;
  logic [15:0] statusWord;
  logic [15:0] hvWord;
  logic        cmdPending;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hvstat_top uut (
    .clk(clk), .rst_n(rst_n), .linePos(linePos), .wideMode(wideMode),
    .vCount(vCount), .latchEnable(latchEnable), .fifoLevel(fifoLevel),
    .dmaActive(dmaActive), .vblank(vblank), .cmdFirstHalf(cmdFirstHalf),
    .statusRead(statusRead), .statusWord(statusWord), .hvWord(hvWord),
    .cmdPending(cmdPending)
  );

  // stimulus fields: pos[31:16] wide[15] vcount[14:7] level[6:3] dma[2] vb[1] pad[0]
  localparam int NVEC = 16;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd31,   1'b1, 8'd5,   4'd0, 1'b0, 1'b0, 1'b0},
    {16'd32,   1'b1, 8'd6,   4'd1, 1'b0, 1'b1, 1'b0},
    {16'd125,  1'b1, 8'd7,   4'd3, 1'b0, 1'b0, 1'b0},
    {16'd126,  1'b1, 8'd8,   4'd4, 1'b0, 1'b0, 1'b0},
    {16'd39,   1'b0, 8'd9,   4'd5, 1'b0, 1'b0, 1'b0},
    {16'd40,   1'b0, 8'd10,  4'd4, 1'b1, 1'b0, 1'b0},
    {16'd123,  1'b0, 8'd11,  4'd0, 1'b1, 1'b1, 1'b0},
    {16'd124,  1'b0, 8'd12,  4'd2, 1'b0, 1'b0, 1'b0},
    {16'd544,  1'b1, 8'd200, 4'd9, 1'b0, 1'b0, 1'b0},
    {16'd511,  1'b1, 8'd255, 4'd0, 1'b0, 1'b1, 1'b0},
    {16'd511,  1'b0, 8'd1,   4'd15,1'b0, 1'b0, 1'b0},
    {16'd1024, 1'b0, 8'd2,   4'd1, 1'b0, 1'b0, 1'b0},
    {16'd300,  1'b1, 8'd100, 4'd2, 1'b0, 1'b0, 1'b0},
    {16'd300,  1'b0, 8'd100, 4'd2, 1'b0, 1'b0, 1'b0},
    {16'd65535,1'b1, 8'd77,  4'd4, 1'b1, 1'b1, 1'b0},
    {16'd8,    1'b0, 8'd0,   4'd0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [15:0] expStatus(input logic [15:0] pos, input logic wide,
                                            input logic [3:0] lvl, input logic dma,
                                            input logic vb);
    int p;
    logic hb;
    p = int'(pos) % 512;
    hb = wide ? (p >= 32 && p < 126) : (p >= 40 && p < 124);
    return {11'd0, dma, vb, hb, (!dma && lvl >= 4), (dma || lvl == 0)};
  endfunction

  function automatic logic [15:0] expHv(input logic [15:0] pos, input logic wide,
                                        input logic [7:0] vc);
    int p;
    int h;
    p = int'(pos) % 512;
    h = (p * (wide ? 110 : 90)) / 256;
    return {vc, h[7:0]};
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, result is due after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [15:0] pos, input logic wide, input logic [7:0] vc,
                       input logic [3:0] lvl, input logic dma, input logic vb);
    @(negedge clk);
    linePos = pos; wideMode = wide; vCount = vc;
    fifoLevel = lvl; dmaActive = dma; vblank = vb;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] frozen;
    rst_n = 1'b0; linePos = '0; wideMode = 1'b0; vCount = '0; latchEnable = 1'b0;
    fifoLevel = '0; dmaActive = 1'b0; vblank = 1'b0; cmdFirstHalf = 1'b0; statusRead = 1'b0;
    linePos = 16'd50; vCount = 8'h33; fifoLevel = 4'd2; vblank = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check16("R1 status", statusWord, 16'h0);
    check16("R1 hv", hvWord, 16'h0);
    check16("R1 pending", {15'd0, cmdPending}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector walk: R2 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][31:16], VEC[i][15], VEC[i][14:7], VEC[i][6:3], VEC[i][2], VEC[i][1]);
      step();
      check16("R5/R6/R7/R8 status", statusWord,
              expStatus(VEC[i][31:16], VEC[i][15], VEC[i][6:3], VEC[i][2], VEC[i][1]));
      check16("R2 hv", hvWord, expHv(VEC[i][31:16], VEC[i][15], VEC[i][14:7]));
    end

    // R10: output tracks the previous edge, not the current input
    drive(16'd100, 1'b1, 8'd20, 4'd0, 1'b0, 1'b0);
    step();
    @(negedge clk);
    vCount = 8'd21;
    #0.5;
    check16("R10 latency", hvWord, expHv(16'd100, 1'b1, 8'd20));
    step();
    check16("R10 update", hvWord, expHv(16'd100, 1'b1, 8'd21));

    // R3 capture and hold
    drive(16'd200, 1'b1, 8'd40, 4'd0, 1'b0, 1'b0);
    latchEnable = 1'b1;
    step();
    frozen = expHv(16'd200, 1'b1, 8'd40);
    check16("R3 capture", hvWord, frozen);
    for (int k = 0; k < 4; k++) begin
      drive(16'(300 + k * 37), k[0], 8'(60 + k), 4'd0, 1'b0, 1'b0);
      step();
      check16("R3/R4 hold", hvWord, frozen);
    end
    // R4 release then recapture
    drive(16'd400, 1'b0, 8'd90, 4'd0, 1'b0, 1'b0);
    latchEnable = 1'b0;
    step();
    check16("R4 release live", hvWord, expHv(16'd400, 1'b0, 8'd90));
    drive(16'd77, 1'b0, 8'd91, 4'd0, 1'b0, 1'b0);
    latchEnable = 1'b1;
    step();
    frozen = expHv(16'd77, 1'b0, 8'd91);
    check16("R4 recapture", hvWord, frozen);
    drive(16'd450, 1'b1, 8'd92, 4'd0, 1'b0, 1'b0);
    step();
    check16("R4 new hold", hvWord, frozen);
    @(negedge clk);
    latchEnable = 1'b0;

    // R9 pending flag
    @(negedge clk);
    cmdFirstHalf = 1'b1;
    step();
    check16("R9 set", {15'd0, cmdPending}, 16'd1);
    @(negedge clk);
    cmdFirstHalf = 1'b0;
    step();
    check16("R9 keep", {15'd0, cmdPending}, 16'd1);
    @(negedge clk);
    statusRead = 1'b1;
    step();
    check16("R9 clear", {15'd0, cmdPending}, 16'd0);
    @(negedge clk);
    statusRead = 1'b0;
    cmdFirstHalf = 1'b1;
    step();
    check16("R9 set again", {15'd0, cmdPending}, 16'd1);
    @(negedge clk);
    statusRead = 1'b1;
    step();
    check16("R9 clear wins", {15'd0, cmdPending}, 16'd0);
    @(negedge clk);
    statusRead = 1'b0;
    cmdFirstHalf = 1'b0;

    // R1 reset clears pending and latch
    cmdFirstHalf = 1'b1;
    step();
    @(negedge clk);
    cmdFirstHalf = 1'b0;
    rst_n = 1'b0;
    step();
    check16("R1 reset pending", {15'd0, cmdPending}, 16'd0);
    check16("R1 reset hv", hvWord, 16'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule